// File: doc/BRIEF.md
# Timestamp-Ordered Transaction Queue

Each processor in a snooping system receives coherence transactions from a network that delivers them in no particular order. Every transaction carries a 2-bit logical timestamp set by its sender. This block holds the arrivals in a small buffer. It hands them to the local snoop logic in one global order: by timestamp first, then by ascending source id among transactions that share a timestamp.

A separate input, `safe_ts`, carries the network's promise that every later arrival will have a timestamp strictly after it. A held transaction is released only once its timestamp is at or before that point. Timestamps wrap modulo 4, so all comparisons are made relative to `safe_ts`. The environment keeps these conditions:
- Arrivals carry `safe_ts+1` or `safe_ts+2`.
- Held entries never fall behind `safe_ts-1`.
- One source sends at most one transaction per timestamp value.

Both streams use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. The input side stalls the network by dropping `in_ready` when every slot is occupied. The output side holds its head transaction while `out_ready` is low. Each released transaction is marked when its source id equals the local processor id. That tells the snoop logic whether the transaction takes effect as the processor's own or needs an invalidate or a response.

Top module: `tsq_order_queue`

## Requirements
- R1: After reset, `out_valid` and `safe_jump_err` are 0 and `in_ready` is 1.
- R2: A transaction is accepted on every edge with `in_valid` and `in_ready` high. `in_ready` is 0 exactly when DEPTH (16) transactions are held, and an offer made then is not stored.
- R3: `out_valid` is 1 only when the chosen transaction's timestamp equals `safe_ts` or `safe_ts-1` (mod 4). Held transactions with timestamps `safe_ts+1` or `safe_ts+2` keep `out_valid` at 0.
- R4: Held transactions are released in ascending order of age key `(ts - safe_ts + 1) mod 4`. The key is 0 for the oldest value `safe_ts-1` and 3 for `safe_ts+2`. Equal timestamps are released by ascending source id.
- R5: `out_own` is 1 exactly when `out_src` equals `my_id`.
- R6: While `out_valid` is 1, `out_ready` is 0 and `safe_ts` does not change, the same transaction stays on the output.
- R7: `safe_jump_err` is 1 for one cycle, one cycle after `safe_ts` moves forward by 2 or 3 (mod 4) between consecutive cycles. It stays 0 when `safe_ts` holds or steps by 1.
- R8: Ordering holds across the wrap of the timestamp. With `safe_ts`=0, a held timestamp 3 is released before a held timestamp 0.
- R9: Every released transaction carries the timestamp, source, address and kind it was accepted with. Each accepted transaction is released exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_id | input | SRC_W | Id of the local processor |
| safe_ts | input | 2 | Network guarantee: no later arrival has a timestamp at or before this |
| in_valid | input | 1 | Arriving transaction present |
| in_ready | output | 1 | A free slot exists |
| in_ts | input | 2 | Arriving logical timestamp |
| in_src | input | SRC_W | Arriving source id |
| in_addr | input | ADDR_W | Arriving block address |
| in_kind | input | KIND_W | Arriving transaction type |
| out_valid | output | 1 | Next transaction in order is releasable |
| out_ready | input | 1 | Snoop logic takes the transaction |
| out_ts | output | 2 | Released timestamp |
| out_src | output | SRC_W | Released source id |
| out_addr | output | ADDR_W | Released address |
| out_kind | output | KIND_W | Released type |
| out_own | output | 1 | Released transaction came from this processor |
| safe_jump_err | output | 1 | Pulse: `safe_ts` skipped a value |

## Verification
The hardest case to reach from the ports is a head entry whose timestamp has already fallen behind `safe_ts`, competing with newer releasable entries across the 3-to-0 wrap. The stimulus builds this state with `out_ready` held low. It loads timestamps 3 and 0 while `safe_ts` is 2, then steps `safe_ts` through 3 to 0 before opening the output. The stalled head is also checked for stability during this window. A second pass fills all sixteen slots in reverse source order and makes an extra offer while the buffer is full. Draining then shows both the sort order and that the rejected offer never appears.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int TS_W = 2;

  // Age of a timestamp relative to the safe point: 0 = safe-1 (oldest),
  // 1 = safe, 2 = safe+1, 3 = safe+2. Keys 0 and 1 are releasable.
  function automatic logic [TS_W-1:0] rel_key(input logic [TS_W-1:0] ts,
                                               input logic [TS_W-1:0] safe);
    return ts - safe + TS_W'(1);
  endfunction
endpackage

// File: rtl/tsq_free_pick.sv
module tsq_free_pick #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     used,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tsq_head_pick.sv
module tsq_head_pick
  import tsq_pkg::*;
#(
  parameter int N     = 16,
  parameter int SRC_W = 4,
  localparam int IDX_W = $clog2(N),
  localparam int CMP_W = TS_W + SRC_W
) (
  input  logic [N-1:0]       used,
  input  logic [N*TS_W-1:0]  ts_flat,
  input  logic [N*SRC_W-1:0] src_flat,
  input  logic [TS_W-1:0]    safe,
  output logic               any,
  output logic [IDX_W-1:0]   idx,
  output logic [TS_W-1:0]    key
);
  logic [CMP_W-1:0] best;
  logic [CMP_W-1:0] cand;

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '1;
    cand = '0;
    for (int i = 0; i < N; i++) begin
      cand = {rel_key(ts_flat[i*TS_W +: TS_W], safe), src_flat[i*SRC_W +: SRC_W]};
      if (used[i] && (!any || cand < best)) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        best = cand;
      end
    end
    key = best[CMP_W-1 -: TS_W];
  end
endmodule

// File: rtl/tsq_safe_watch.sv
module tsq_safe_watch
  import tsq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] safe,
  output logic            jump_err
);
  logic [TS_W-1:0] prev_q;
  logic            seen_q;
  logic [TS_W-1:0] step;

  assign step = safe - prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      seen_q   <= 1'b0;
      jump_err <= 1'b0;
    end else begin
      prev_q   <= safe;
      seen_q   <= 1'b1;
      jump_err <= seen_q && (step > TS_W'(1));
    end
  end
endmodule

// File: rtl/tsq_order_queue.sv
module tsq_order_queue
  import tsq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SRC_W  = 4,
  parameter int ADDR_W = 32,
  parameter int KIND_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  my_id,
  input  logic [TS_W-1:0]   safe_ts,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TS_W-1:0]   in_ts,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [KIND_W-1:0] in_kind,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [TS_W-1:0]   out_ts,
  output logic [SRC_W-1:0]  out_src,
  output logic [ADDR_W-1:0] out_addr,
  output logic [KIND_W-1:0] out_kind,
  output logic              out_own,
  output logic              safe_jump_err
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  used_q;
  logic [TS_W-1:0]   ts_q   [DEPTH];
  logic [SRC_W-1:0]  src_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [KIND_W-1:0] kind_q [DEPTH];

  logic [DEPTH*TS_W-1:0]  ts_flat;
  logic [DEPTH*SRC_W-1:0] src_flat;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      ts_flat[i*TS_W +: TS_W]    = ts_q[i];
      src_flat[i*SRC_W +: SRC_W] = src_q[i];
    end
  end

  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic             head_any;
  logic [IDX_W-1:0] head_idx;
  logic [TS_W-1:0]  head_key;
  logic             push, pop;

  tsq_free_pick #(.N(DEPTH)) u_free (
    .used (used_q),
    .found(free_found),
    .idx  (free_idx)
  );

  tsq_head_pick #(.N(DEPTH), .SRC_W(SRC_W)) u_head (
    .used    (used_q),
    .ts_flat (ts_flat),
    .src_flat(src_flat),
    .safe    (safe_ts),
    .any     (head_any),
    .idx     (head_idx),
    .key     (head_key)
  );

  tsq_safe_watch u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .safe    (safe_ts),
    .jump_err(safe_jump_err)
  );

  assign in_ready  = free_found;
  assign out_valid = head_any && (head_key <= TS_W'(1));
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else begin
      if (push) used_q[free_idx] <= 1'b1;
      if (pop)  used_q[head_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      ts_q[free_idx]   <= in_ts;
      src_q[free_idx]  <= in_src;
      addr_q[free_idx] <= in_addr;
      kind_q[free_idx] <= in_kind;
    end
  end

  assign out_ts   = ts_q[head_idx];
  assign out_src  = src_q[head_idx];
  assign out_addr = addr_q[head_idx];
  assign out_kind = kind_q[head_idx];
  assign out_own  = (src_q[head_idx] == my_id);
endmodule

// File: rtl/tsq_order_queue_chk.sv
module tsq_order_queue_chk #(
  parameter int DEPTH  = 16,
  parameter int SRC_W  = 4,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DEPTH-1:0]  used_q,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_ts,
  input logic [SRC_W-1:0]  out_src,
  input logic [ADDR_W-1:0] out_addr,
  input logic [1:0]        safe_ts,
  input logic              safe_jump_err
);
  // R2: back-pressure only when every slot is occupied
  a_r2_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> ($countones(used_q) == DEPTH));

  // R3: release only at or before the safe point
  a_r3_release_safe: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((2'(safe_ts - out_ts) == 2'd0) || (2'(safe_ts - out_ts) == 2'd1)));

  // R3: nothing offered from an empty buffer
  a_r3_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (used_q != '0));

  // R6: stalled head stays put while the safe point holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (!$stable(safe_ts) || (out_valid && $stable(out_src) && $stable(out_addr))));

  // R7: an error pulse follows a skip of two or more values
  a_r7_jump: assert property (@(posedge clk) disable iff (!rst_n)
    safe_jump_err |-> (2'($past(safe_ts) - $past(safe_ts, 2)) > 2'd1));
endmodule

bind tsq_order_queue tsq_order_queue_chk #(
  .DEPTH(DEPTH), .SRC_W(SRC_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .used_q       (used_q),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_ts       (out_ts),
  .out_src      (out_src),
  .out_addr     (out_addr),
  .safe_ts      (safe_ts),
  .safe_jump_err(safe_jump_err)
);

// File: tb/sim_tsq_order_queue.sv
`timescale 1ns/1ps
module sim_tsq_order_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  my_id = 4'd5;
  logic [1:0]  safe_ts = 2'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_ts = '0;
  logic [3:0]  in_src = '0;
  logic [31:0] in_addr = '0;
  logic [1:0]  in_kind = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [1:0]  out_ts;
  logic [3:0]  out_src;
  logic [31:0] out_addr;
  logic [1:0]  out_kind;
  logic        out_own;
  logic        safe_jump_err;

  always #2 clk = ~clk;

  tsq_order_queue u0 (
    .clk(clk), .rst_n(rst_n), .my_id(my_id), .safe_ts(safe_ts),
    .in_valid(in_valid), .in_ready(in_ready), .in_ts(in_ts), .in_src(in_src),
    .in_addr(in_addr), .in_kind(in_kind),
    .out_valid(out_valid), .out_ready(out_ready), .out_ts(out_ts), .out_src(out_src),
    .out_addr(out_addr), .out_kind(out_kind), .out_own(out_own),
    .safe_jump_err(safe_jump_err)
  );

  typedef struct {
    logic [1:0]  ts;
    logic [3:0]  src;
    logic [31:0] addr;
    logic [1:0]  kind;
  } tx_t;

  tx_t pend[$];
  tx_t exp_q[$];
  int  checks = 0;
  int  failures = 0;
  bit  finished = 0;

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard on each output handshake
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected release", {out_ts, out_src, out_addr}, 64'h0);
      end else begin
        tx_t e;
        logic [40:0] act, expv;
        e = exp_q.pop_front();
        act  = {out_ts, out_src, out_addr, out_kind, out_own};
        expv = {e.ts, e.src, e.addr, e.kind, (e.src == my_id)};
        check(act == expv, "R4/R5/R9 release order and fields", 64'(act), 64'(expv));
      end
    end
  end

  task automatic drive_tx(logic [1:0] ts, logic [3:0] src);
    tx_t t;
    t.ts = ts; t.src = src;
    t.addr = 32'hC000_0000 + {24'd0, src, 2'b00, ts};
    t.kind = src[1:0] ^ ts;
    @(posedge clk); #1;
    in_valid = 1'b1; in_ts = t.ts; in_src = t.src; in_addr = t.addr; in_kind = t.kind;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
    pend.push_back(t);
  endtask

  // Sort pending items by (age key relative to rel_safe, source) into the scoreboard
  task automatic commit(logic [1:0] rel_safe);
    while (pend.size() > 0) begin
      int best = 0;
      for (int i = 1; i < pend.size(); i++) begin
        logic [5:0] ci, cb;
        ci = {2'(pend[i].ts - rel_safe + 2'd1), pend[i].src};
        cb = {2'(pend[best].ts - rel_safe + 2'd1), pend[best].src};
        if (ci < cb) best = i;
      end
      exp_q.push_back(pend[best]);
      pend.delete(best);
    end
  endtask

  task automatic set_safe(logic [1:0] v);
    @(posedge clk); #1;
    safe_ts = v;
  endtask

  task automatic wait_drain(string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < 400) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, tag, 64'(exp_q.size()), 64'd0);
    check(out_valid == 1'b0, tag, 64'(out_valid), 64'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);
    check(safe_jump_err == 1'b0, "R1 safe_jump_err", 64'(safe_jump_err), 64'd0);
    rst_n = 1'b1;

    // Scenario A: future entries are held until the safe point covers them (R3, R4, R5)
    out_ready = 1'b1;
    drive_tx(2'd1, 4'd6);
    drive_tx(2'd2, 4'd5);
    drive_tx(2'd1, 4'd2);
    drive_tx(2'd2, 4'd1);
    drive_tx(2'd1, 4'd5);
    commit(2'd2);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R3 future entries held", 64'(out_valid), 64'd0);
    check(exp_q.size() == 5, "R3 nothing released early", 64'(exp_q.size()), 64'd5);
    set_safe(2'd1);
    repeat (6) @(negedge clk);
    check(exp_q.size() == 2, "R3 only safe timestamp released", 64'(exp_q.size()), 64'd2);
    set_safe(2'd2);
    wait_drain("R4 drain A");

    // Scenario B: wrap with an entry older than the safe point (R8, R6)
    out_ready = 1'b0;
    drive_tx(2'd0, 4'd3);
    drive_tx(2'd3, 4'd9);
    drive_tx(2'd0, 4'd1);
    drive_tx(2'd3, 4'd4);
    commit(2'd0);
    set_safe(2'd3);
    @(negedge clk);
    check(out_valid == 1'b1 && out_src == 4'd4, "R6 stalled head present",
          64'({out_valid, out_src}), 64'({1'b1, 4'd4}));
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b1 && out_src == 4'd4 && out_ts == 2'd3, "R6 stalled head held",
          64'({out_valid, out_src, out_ts}), 64'({1'b1, 4'd4, 2'd3}));
    set_safe(2'd0);
    @(negedge clk);
    check(out_ts == 2'd3 && out_src == 4'd4, "R8 older ts3 ahead of ts0",
          64'({out_ts, out_src}), 64'({2'd3, 4'd4}));
    out_ready = 1'b1;
    wait_drain("R8 drain B");

    // Scenario C: fill all slots, offer one more, drain in order (R2, R4)
    out_ready = 1'b0;
    for (int s = 15; s >= 0; s--) drive_tx(2'd1, 4'(s));
    commit(2'd1);
    @(negedge clk);
    check(in_ready == 1'b0, "R2 in_ready low when full", 64'(in_ready), 64'd0);
    @(posedge clk); #1;
    in_valid = 1'b1; in_ts = 2'd2; in_src = 4'd7; in_addr = 32'hDEAD_0000; in_kind = 2'd3;
    repeat (3) @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R3 full but not yet safe", 64'(out_valid), 64'd0);
    set_safe(2'd1);
    out_ready = 1'b1;
    wait_drain("R2 drain C, rejected offer absent");
    check(in_ready == 1'b1, "R2 in_ready back after drain", 64'(in_ready), 64'd1);

    // Scenario D: safe point checks (R7)
    set_safe(2'd3);
    @(posedge clk);
    @(negedge clk);
    check(safe_jump_err == 1'b1, "R7 jump by two flagged", 64'(safe_jump_err), 64'd1);
    @(negedge clk);
    check(safe_jump_err == 1'b0, "R7 pulse is one cycle", 64'(safe_jump_err), 64'd0);
    set_safe(2'd0);
    @(posedge clk);
    @(negedge clk);
    check(safe_jump_err == 1'b0, "R7 step by one not flagged", 64'(safe_jump_err), 64'd0);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule